// File: doc/BRIEF.md
# Configurable Logic Slice

This block models one configurable logic slice as a synthesizable netlist. It has four lanes. Each lane holds a 6-input lookup table, one stage of a 4-bit carry chain and two storage flip-flops, so the slice has eight flip-flops in all. A flat configuration vector sets every choice the slice makes. That vector holds the truth tables, the fixed output and data-select muxes, the source of each carry generate term, the reset value of each flip-flop and the polarity of the shared clock. None of these muxes has a runtime select, and the configuration must stay constant while the clock runs.

The configuration can arrange a slice in several ways. It can be a wide combinational function with one 6-input function per lane. It can register that function. It can be a plain 8-bit register fed from the bypass inputs. It can be a 4-bit ripple adder, and several slices can be chained through carry-in and carry-out. All flip-flops share one clock enable and one synchronous set/reset.

Top module: `cfg_slice`

## Requirements
- R1: For every lane i, the lookup-table result equals bit `a` of truth table i. The address `a` takes lane input j (`lut_in_i[i*6+j]`) as address bit j, and truth table i occupies `cfg_i[i*64 +: 64]`.
- R2: The lane configuration byte of lane i sits at `cfg_i[256+i*8 +: 8]`. Its bits [1:0] select `comb_o[i]`: 0 gives the LUT result, 1 the sum bit, 2 the stage carry-out and 3 `byp_i[i]`.
- R3: Carry stage i takes the LUT result as its propagate term. The stage carry-out equals the incoming carry when propagate is 1, and the generate term when propagate is 0. The sum bit is propagate XOR the incoming carry. The stage 0 carry is `cin_i`, and `cout_o` is the stage 3 carry-out. Lane byte bit 2 selects the generate term: 0 takes `byp_i[i]` and 1 takes lane input 0.
- R4: Lane byte bits [4:3] select the data of main flip-flop i: 0 the LUT result, 1 the sum, 2 `byp_i[i]`, 3 the stage carry-out. Bit 5 selects the data of aux flip-flop i: 0 `aux_i[i]`, 1 the LUT result. The outputs are `ffm_o` and `ffa_o`.
- R5: On an active clock edge with `sr_i` low and `ce_i` high, every flip-flop loads its selected data.
- R6: On an active clock edge with `sr_i` high, every flip-flop loads its reset value whatever `ce_i` is. Lane byte bit 6 gives the main flip-flop's reset value and bit 7 gives the aux flip-flop's.
- R7: On an active clock edge with `sr_i` low and `ce_i` low, every flip-flop keeps its value.
- R8: When `cfg_i[288]` is 0, the active edge is the rising edge of `clk_i`. When it is 1, the active edge is the falling edge, and a rising edge changes no flip-flop.
- R9: With each LUT set to XOR lane inputs 0 and 1, generate taken from lane input 0 and `comb_o` showing the sum, the slice adds two 4-bit operands. `comb_o` then equals (A+B+cin) mod 16 and `cout_o` equals bit 4 of that total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock before the polarity mux |
| ce_i | input | 1 | Shared clock enable |
| sr_i | input | 1 | Shared synchronous set/reset, active high |
| cfg_i | input | 289 | Static configuration: truth tables, lane bytes, clock polarity |
| lut_in_i | input | 24 | Six inputs per lane, lane i at bits [i*6 +: 6] |
| byp_i | input | 4 | Per-lane bypass data, also a generate source |
| aux_i | input | 4 | Per-lane bypass data for the aux flip-flops |
| cin_i | input | 1 | Carry into stage 0 |
| comb_o | output | 4 | Per-lane combinational output |
| ffm_o | output | 4 | Main flip-flop outputs |
| ffa_o | output | 4 | Aux flip-flop outputs |
| cout_o | output | 1 | Carry out of stage 3 |

## Verification
The assertions check the flip-flop rules on every active edge: capture when enabled, hold when disabled, and the configured reset value after a set/reset. They also check the two chain extremes on every edge: when all propagates are 1 the carry passes straight through, and when all are 0 the final generate term drives the carry-out. Only the bench's scenarios can show the rest. That covers the mapping of truth-table bits to addresses, every select encoding, the arithmetic result of the adder setup across all operand pairs, and the fact that the inverted clock setting ignores rising edges.

// File: rtl/slice_pkg.sv
package slice_pkg;

   // Fixed-function choice for the per-lane combinational output
   typedef enum logic [1:0] {
      CO_LUT   = 2'd0,
      CO_SUM   = 2'd1,
      CO_CARRY = 2'd2,
      CO_BYP   = 2'd3
   } comb_sel_e;

   // Fixed-function choice for the main flip-flop data
   typedef enum logic [1:0] {
      FD_LUT   = 2'd0,
      FD_SUM   = 2'd1,
      FD_BYP   = 2'd2,
      FD_CARRY = 2'd3
   } ffd_sel_e;

   // One configuration byte per lane (MSB first)
   typedef struct packed {
      logic      aux_init;
      logic      main_init;
      logic      aux_sel;
      ffd_sel_e  main_sel;
      logic      gen_sel;
      comb_sel_e comb_sel;
   } lane_cfg_t;

   localparam int LANE_CFG_W = $bits(lane_cfg_t);

   function automatic logic pick4(input logic [1:0] sel, input logic d0,
                                  input logic d1, input logic d2, input logic d3);
      logic r;
      unique case (sel)
         2'd0:    r = d0;
         2'd1:    r = d1;
         2'd2:    r = d2;
         default: r = d3;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/slice_lut.sv
module slice_lut #(
   parameter  int K    = 6,
   localparam int TT_W = 1 << K
) (
   input  logic [TT_W-1:0] tt_i,
   input  logic [K-1:0]    sel_i,
   output logic            o
);

   if (K < 1 || K > 6) begin : g_bad_k
      $error("slice_lut: K must lie in 1..6");
   end

   assign o = tt_i[sel_i];

endmodule

// File: rtl/slice_carry.sv
module slice_carry #(
   parameter int N = 4
) (
   input  logic [N-1:0] prop_i,
   input  logic [N-1:0] gen_i,
   input  logic         cin_i,
   output logic [N-1:0] sum_o,
   output logic [N-1:0] co_o,
   output logic         cout_o
);

   if (N < 1) begin : g_bad_n
      $error("slice_carry: N must be at least 1");
   end

   logic [N:0] chain;
   assign chain[0] = cin_i;

   for (genvar s = 0; s < N; s++) begin : g_stage
      // MUX stage: pass the incoming carry or inject the generate term
      assign chain[s+1] = prop_i[s] ? chain[s] : gen_i[s];
      // XOR stage
      assign sum_o[s]   = prop_i[s] ^ chain[s];
   end

   assign co_o   = chain[N:1];
   assign cout_o = chain[N];

endmodule

// File: rtl/slice_ff.sv
module slice_ff (
   input  logic clk_i,
   input  logic ce_i,
   input  logic sr_i,
   input  logic init_i,
   input  logic d_i,
   output logic q_o
);

   always_ff @(posedge clk_i) begin
      if (sr_i)      q_o <= init_i;
      else if (ce_i) q_o <= d_i;
   end

   // R6: set/reset loads the configured value
   a_r6_sync_reset: assert property (@(posedge clk_i) disable iff (sr_i)
      $past(sr_i) |-> (q_o == $past(init_i)));

   // R5: enabled edge captures the data
   a_r5_capture: assert property (@(posedge clk_i) disable iff (sr_i)
      (!$past(sr_i) && $past(ce_i)) |-> (q_o == $past(d_i)));

   // R7: disabled edge holds
   a_r7_hold: assert property (@(posedge clk_i) disable iff (sr_i)
      (!$past(sr_i) && !$past(ce_i)) |-> $stable(q_o));

endmodule

// File: rtl/cfg_slice.sv
module cfg_slice
   import slice_pkg::*;
#(
   parameter  int NUM_LUT    = 4,
   parameter  int LUT_K      = 6,
   parameter  bit CLK_INV_EN = 1'b1,
   localparam int TT_W       = 1 << LUT_K,
   localparam int LBASE      = NUM_LUT * TT_W,
   localparam int INV_BIT    = LBASE + NUM_LUT * LANE_CFG_W,
   localparam int CFG_W      = INV_BIT + 1
) (
   input  logic                     clk_i,
   input  logic                     ce_i,
   input  logic                     sr_i,
   input  logic [CFG_W-1:0]         cfg_i,
   input  logic [NUM_LUT*LUT_K-1:0] lut_in_i,
   input  logic [NUM_LUT-1:0]       byp_i,
   input  logic [NUM_LUT-1:0]       aux_i,
   input  logic                     cin_i,
   output logic [NUM_LUT-1:0]       comb_o,
   output logic [NUM_LUT-1:0]       ffm_o,
   output logic [NUM_LUT-1:0]       ffa_o,
   output logic                     cout_o
);

   if (NUM_LUT < 1) begin : g_bad_lanes
      $error("cfg_slice: NUM_LUT must be at least 1");
   end
   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("cfg_slice: LUT_K must lie in 2..6");
   end

   // Clock polarity mux, fixed by configuration
   logic sclk;
   if (CLK_INV_EN) begin : g_clk_mux
      assign sclk = cfg_i[INV_BIT] ? ~clk_i : clk_i;
   end else begin : g_clk_thru
      assign sclk = clk_i;
   end

   logic [NUM_LUT-1:0] lut_r, gen_t, sum_t, co_t, dmain, daux;

   slice_carry #(.N(NUM_LUT)) u_carry (
      .prop_i (lut_r),
      .gen_i  (gen_t),
      .cin_i  (cin_i),
      .sum_o  (sum_t),
      .co_o   (co_t),
      .cout_o (cout_o)
   );

   for (genvar i = 0; i < NUM_LUT; i++) begin : g_lane
      lane_cfg_t lc;
      assign lc = lane_cfg_t'(cfg_i[LBASE + i*LANE_CFG_W +: LANE_CFG_W]);

      slice_lut #(.K(LUT_K)) u_lut (
         .tt_i  (cfg_i[i*TT_W +: TT_W]),
         .sel_i (lut_in_i[i*LUT_K +: LUT_K]),
         .o     (lut_r[i])
      );

      assign gen_t[i]  = lc.gen_sel ? lut_in_i[i*LUT_K] : byp_i[i];
      assign comb_o[i] = pick4(lc.comb_sel, lut_r[i], sum_t[i], co_t[i], byp_i[i]);
      assign dmain[i]  = pick4(lc.main_sel, lut_r[i], sum_t[i], byp_i[i], co_t[i]);
      assign daux[i]   = lc.aux_sel ? lut_r[i] : aux_i[i];

      slice_ff u_ff_main (
         .clk_i  (sclk),
         .ce_i   (ce_i),
         .sr_i   (sr_i),
         .init_i (lc.main_init),
         .d_i    (dmain[i]),
         .q_o    (ffm_o[i])
      );

      slice_ff u_ff_aux (
         .clk_i  (sclk),
         .ce_i   (ce_i),
         .sr_i   (sr_i),
         .init_i (lc.aux_init),
         .d_i    (daux[i]),
         .q_o    (ffa_o[i])
      );
   end

   // R3: all stages propagating means carry-in reaches carry-out
   a_r3_carry_pass: assert property (@(posedge sclk) disable iff (sr_i)
      (&lut_r) |-> (cout_o == cin_i));

   // R3: no stage propagating means the top generate term drives carry-out
   a_r3_carry_kill: assert property (@(posedge sclk) disable iff (sr_i)
      (lut_r == '0) |-> (cout_o == gen_t[NUM_LUT-1]));

endmodule

// File: tb/cfg_slice_tb.sv
module cfg_slice_tb;

   localparam int CLK_PER = 10;
   localparam int NL      = 4;
   localparam int K       = 6;
   localparam int TTW     = 64;
   localparam int LW      = 8;
   localparam int LBASE   = NL * TTW;
   localparam int INVB    = LBASE + NL * LW;
   localparam int CW      = INVB + 1;

   logic            clk_i = 1'b0;
   logic            ce_i  = 1'b0;
   logic            sr_i  = 1'b1;
   logic [CW-1:0]   cfg_i = '0;
   logic [NL*K-1:0] lut_in_i = '0;
   logic [NL-1:0]   byp_i = '0;
   logic [NL-1:0]   aux_i = '0;
   logic            cin_i = 1'b0;
   logic [NL-1:0]   comb_o, ffm_o, ffa_o;
   logic            cout_o;

   int            n_chk  = 0;
   int            n_err  = 0;
   logic          cmp_en = 1'b0;
   logic [CW-1:0] nc     = '0;

   always #(CLK_PER/2) clk_i = ~clk_i;

   cfg_slice u_dut (
      .clk_i    (clk_i),
      .ce_i     (ce_i),
      .sr_i     (sr_i),
      .cfg_i    (cfg_i),
      .lut_in_i (lut_in_i),
      .byp_i    (byp_i),
      .aux_i    (aux_i),
      .cin_i    (cin_i),
      .comb_o   (comb_o),
      .ffm_o    (ffm_o),
      .ffa_o    (ffa_o),
      .cout_o   (cout_o)
   );

   // ---------------- behavioural reference ----------------
   logic [NL-1:0] e_comb, e_dm, e_da, e_mi, e_ai, m_main, m_aux, nx_main, nx_aux;
   logic          e_cout;

   always_comb begin
      int   carry;
      carry = int'(cin_i);
      for (int i = 0; i < NL; i++) begin
         int lut, g, s, co, addr;
         addr = int'(lut_in_i[i*K +: K]);
         lut  = int'(cfg_i[i*TTW + addr]);
         g    = cfg_i[LBASE+i*LW+2] ? int'(lut_in_i[i*K]) : int'(byp_i[i]);
         s    = (lut + carry) % 2;
         co   = (lut == 1) ? carry : g;
         case (cfg_i[LBASE+i*LW +: 2])
            2'd0: e_comb[i] = lut[0];
            2'd1: e_comb[i] = s[0];
            2'd2: e_comb[i] = co[0];
            default: e_comb[i] = byp_i[i];
         endcase
         case (cfg_i[LBASE+i*LW+3 +: 2])
            2'd0: e_dm[i] = lut[0];
            2'd1: e_dm[i] = s[0];
            2'd2: e_dm[i] = byp_i[i];
            default: e_dm[i] = co[0];
         endcase
         e_da[i] = cfg_i[LBASE+i*LW+5] ? lut[0] : aux_i[i];
         e_mi[i] = cfg_i[LBASE+i*LW+6];
         e_ai[i] = cfg_i[LBASE+i*LW+7];
         carry   = co;
      end
      e_cout  = carry[0];
      nx_main = sr_i ? e_mi : (ce_i ? e_dm : m_main);
      nx_aux  = sr_i ? e_ai : (ce_i ? e_da : m_aux);
   end

   always @(posedge clk_i) if (!cfg_i[INVB]) begin m_main <= nx_main; m_aux <= nx_aux; end
   always @(negedge clk_i) if (cfg_i[INVB])  begin m_main <= nx_main; m_aux <= nx_aux; end

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(clk_i) begin
      #1;
      if (cmp_en) begin
         chk("R2 comb output", 32'(comb_o), 32'(e_comb));
         chk("R4 main flops", 32'(ffm_o), 32'(m_main));
         chk("R4 aux flops", 32'(ffa_o), 32'(m_aux));
         chk("R3 carry out", 32'(cout_o), 32'(e_cout));
      end
   end

   task automatic step();
      @(posedge clk_i);
      #3;
   endtask

   task automatic set_lane(input int i, input logic [1:0] cs, input logic gs,
                           input logic [1:0] ms, input logic as, input logic mi, input logic ai);
      nc[LBASE+i*LW +: LW] = {ai, mi, as, ms, gs, cs};
   endtask

   task automatic reconf();
      cmp_en = 1'b0;
      sr_i   = 1'b1;
      ce_i   = 1'b0;
      step();
      cfg_i = nc;
      repeat (3) step();
   endtask

   task automatic go();
      sr_i   = 1'b0;
      ce_i   = 1'b1;
      cmp_en = 1'b1;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   logic [63:0] tt [NL];

   initial begin
      // ---- Scenario 1: 6-input functions, registered, reset values ----
      for (int i = 0; i < NL; i++) begin
         tt[i] = {64'h9E37_79B9_7F4A_7C15, 64'h9E37_79B9_7F4A_7C15} >> (i*13);
         nc[i*TTW +: TTW] = tt[i];
         set_lane(i, 2'd0, 1'b0, 2'd0, 1'b1, i[0], ~i[0]);
      end
      nc[INVB] = 1'b0;
      reconf();
      chk("R6 main reset values", 32'(ffm_o), 32'h0000_000A);
      chk("R6 aux reset values", 32'(ffa_o), 32'h0000_0005);
      go();
      for (int a = 0; a < 64; a++) begin
         lut_in_i = {NL{a[5:0]}};
         #1;
         for (int i = 0; i < NL; i++) chk("R1 lut lookup", 32'(comb_o[i]), 32'(tt[i][a]));
         step();
         for (int i = 0; i < NL; i++) chk("R5 registered lut", 32'(ffm_o[i]), 32'(tt[i][a]));
      end

      // ---- Scenario 2: plain register path, hold, reset over enable ----
      for (int i = 0; i < NL; i++) set_lane(i, 2'd3, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
      reconf();
      go();
      byp_i = 4'h6; aux_i = 4'h9;
      step();
      chk("R4 bypass to main", 32'(ffm_o), 32'h6);
      chk("R4 aux bypass", 32'(ffa_o), 32'h9);
      ce_i = 1'b0; byp_i = 4'h3; aux_i = 4'hC;
      step();
      chk("R7 hold main", 32'(ffm_o), 32'h6);
      chk("R7 hold aux", 32'(ffa_o), 32'h9);
      sr_i = 1'b1;
      step();
      chk("R6 reset with enable low main", 32'(ffm_o), 32'hF);
      chk("R6 reset with enable low aux", 32'(ffa_o), 32'h0);
      sr_i = 1'b0; ce_i = 1'b1;
      step();

      // ---- Scenario 3: 4-bit adder ----
      for (int i = 0; i < NL; i++) begin
         for (int x = 0; x < TTW; x++) nc[i*TTW + x] = x[0] ^ x[1];
         set_lane(i, 2'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
      end
      reconf();
      go();
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) begin
               logic [NL*K-1:0] v;
               int tot;
               v = '0;
               for (int i = 0; i < NL; i++) begin
                  v[i*K]   = a[i];
                  v[i*K+1] = b[i];
               end
               lut_in_i = v; cin_i = c[0];
               tot = a + b + c;
               step();
               chk("R9 adder sum", 32'(comb_o), 32'(tot % 16));
               chk("R9 adder carry", 32'(cout_o), 32'(tot / 16));
            end

      // ---- Scenario 4: carry chain with bypass generate ----
      for (int i = 0; i < NL; i++) begin
         for (int x = 0; x < TTW; x++) nc[i*TTW + x] = x[0];
         set_lane(i, 2'd2, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);
      end
      reconf();
      go();
      for (int p = 0; p < 16; p++)
         for (int g = 0; g < 16; g++)
            for (int c = 0; c < 2; c++) begin
               logic [NL*K-1:0] v;
               logic [NL-1:0]   ec;
               logic            cr;
               v = '0;
               for (int i = 0; i < NL; i++) v[i*K] = p[i];
               lut_in_i = v; byp_i = g[3:0]; cin_i = c[0];
               cr = c[0];
               for (int i = 0; i < NL; i++) begin
                  cr    = p[i] ? cr : g[i];
                  ec[i] = cr;
               end
               step();
               chk("R3 stage carries", 32'(comb_o), 32'(ec));
               chk("R3 chain carry out", 32'(cout_o), 32'(cr));
            end

      // ---- Scenario 5: falling-edge clocking ----
      for (int i = 0; i < NL; i++) set_lane(i, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
      nc[INVB] = 1'b1;
      reconf();
      go();
      byp_i = 4'h5;
      step();
      step();
      @(negedge clk_i); #1;
      byp_i = 4'hA;
      @(posedge clk_i); #2;
      chk("R8 rising edge ignored", 32'(ffm_o), 32'h5);
      @(negedge clk_i); #2;
      chk("R8 falling edge captures", 32'(ffm_o), 32'hA);
      step();

      cmp_en = 1'b0;
      summary();
   end

endmodule